// File: doc/BRIEF.md
# Coherent Split Timer Reader

This block is a bus master that fetches a 32-bit free-running timer from a slave that shows the timer as two 16-bit words. The low half lives at word address 4 and the high half at word address 5, on a 3-bit address bus. Reading the two halves one after the other can return a torn value. This happens when the low half wraps to zero between the two reads and the high half steps up by one.

When `start` is pulsed, the reader fetches the high word, then the low word, then the high word again. If the two high words agree, it returns `{high, low}` and pulses `done`. If they differ, it drops the attempt, counts a retry and runs all three reads again. The master never writes. It keeps at most one strobe in flight. It holds a strobe steady while the slave stalls.

Top module: `split_timer_reader`

## Requirements
- R1: A synchronous reset, asserted at any time, returns the reader to idle in the next cycle: `busy`=0, `bus_stb`=0, `done`=0, `result`=0 and `retries`=0.
- R2: `bus_we` is 0 in every cycle.
- R3: Each attempt issues exactly three accepted strobes, with addresses in the order 5 (high), 4 (low), 5 (high).
- R4: After a strobe is accepted (`bus_stb`=1 and `bus_stall`=0), no new strobe is raised until `bus_ack` has been seen.
- R5: While `bus_stall` is 1, a raised strobe stays raised and its address does not change.
- R6: When both high reads of an attempt are equal, `result` becomes `{high, low}` of that attempt and `done` is 1 for exactly one cycle. In that cycle `busy` is 0.
- R7: When the two high reads differ, the reader restarts with a high read and `retries` increases by one.
- R8: `retries` is cleared by an accepted `start` and saturates at 255.
- R9: A `start` that arrives while `busy` is 1 has no effect. Exactly one `done` and one result follow the original start.
- R10: A `bus_ack` that arrives while the reader is idle is ignored. `busy`, `done` and `result` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a coherent timer read |
| busy | output | 1 | A read sequence is in progress |
| done | output | 1 | One-cycle strobe: `result` is fresh |
| result | output | 32 | Coherent timer value |
| retries | output | 8 | Torn attempts seen in the current or last read, saturating |
| bus_adr | output | 3 | Word address of the request |
| bus_stb | output | 1 | Request strobe |
| bus_we | output | 1 | Write enable, always 0 |
| bus_dat_i | input | 16 | Read data from the slave |
| bus_ack | input | 1 | Slave acknowledge, data valid in the same cycle |
| bus_stall | input | 1 | Slave cannot take the strobe this cycle |

## Verification
The bench builds the reader with its default parameters: a 16-bit data word, a 3-bit address and an 8-bit retry counter. With these values, seeding the modelled timer close to a low-half wrap, and close to the full 32-bit wrap, brings the natural retry path within a few cycles of start. The bench model can also flip a bit in the second high read for a chosen number of attempts. With 300 such attempts the 8-bit counter is driven past 255 in under two thousand cycles, so saturation is reached in a short run.

// File: rtl/split_timer_reader.sv
module split_timer_reader #(
  parameter int DW      = 16,
  parameter int AW      = 3,
  parameter int LO_ADDR = 4,
  parameter int HI_ADDR = 5,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic [2*DW-1:0]  result,
  output logic [CNT_W-1:0] retries,
  output logic [AW-1:0]    bus_adr,
  output logic             bus_stb,
  output logic             bus_we,
  input  logic [DW-1:0]    bus_dat_i,
  input  logic             bus_ack,
  input  logic             bus_stall
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [AW-1:0]    A_LO    = AW'(LO_ADDR);
  localparam logic [AW-1:0]    A_HI    = AW'(HI_ADDR);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;
  typedef enum logic [1:0] {P_HI1, P_LO, P_HI2} ph_t;

  st_t           state;
  ph_t           phase;
  logic [DW-1:0] hi_q, lo_q;

  assign busy    = (state != S_IDLE);
  assign bus_stb = (state == S_REQ);
  assign bus_we  = 1'b0;
  assign bus_adr = (phase == P_LO) ? A_LO : A_HI;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      phase   <= P_HI1;
      hi_q    <= '0;
      lo_q    <= '0;
      result  <= '0;
      retries <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state   <= S_REQ;
          phase   <= P_HI1;
          retries <= '0;
        end
        S_REQ: if (!bus_stall) state <= S_WAIT;
        S_WAIT: if (bus_ack) begin
          case (phase)
            P_HI1: begin
              hi_q  <= bus_dat_i;
              phase <= P_LO;
              state <= S_REQ;
            end
            P_LO: begin
              lo_q  <= bus_dat_i;
              phase <= P_HI2;
              state <= S_REQ;
            end
            default: begin
              phase <= P_HI1;
              if (bus_dat_i == hi_q) begin
                result <= {hi_q, lo_q};
                done   <= 1'b1;
                state  <= S_IDLE;
              end else begin
                state <= S_REQ;
                if (retries != CNT_MAX) retries <= retries + 1'b1;
              end
            end
          endcase
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module split_timer_reader_chk #(
  parameter int AW    = 3,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] retries,
  input logic [AW-1:0]    bus_adr,
  input logic             bus_stb,
  input logic             bus_we,
  input logic             bus_ack,
  input logic             bus_stall
);
  logic pending;
  always_ff @(posedge clk) begin
    if (rst) pending <= 1'b0;
    else if (bus_ack) pending <= 1'b0;
    else if (bus_stb && !bus_stall) pending <= 1'b1;
  end

  a_r2_never_write: assert property (@(posedge clk) disable iff (rst) !bus_we);
  a_r3_addr_legal: assert property (@(posedge clk) disable iff (rst)
    bus_stb |-> (bus_adr == AW'(4) || bus_adr == AW'(5)));
  a_r4_one_in_flight: assert property (@(posedge clk) disable iff (rst)
    pending |-> !bus_stb);
  a_r5_stall_hold: assert property (@(posedge clk) disable iff (rst)
    bus_stb && bus_stall |=> bus_stb && $stable(bus_adr));
  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  a_r8_saturate: assert property (@(posedge clk) disable iff (rst)
    busy && (retries == {CNT_W{1'b1}}) |=> retries == {CNT_W{1'b1}});
  a_r10_idle_ack: assert property (@(posedge clk) disable iff (rst)
    !busy && !start |=> !busy && !done);
endmodule

bind split_timer_reader split_timer_reader_chk #(.AW(AW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .retries(retries), .bus_adr(bus_adr), .bus_stb(bus_stb), .bus_we(bus_we),
  .bus_ack(bus_ack), .bus_stall(bus_stall)
);

// File: tb/sim_split_timer_reader.sv
`timescale 1ns/1ps
module sim_split_timer_reader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        busy, done, bus_stb, bus_we;
  logic [31:0] result;
  logic [7:0]  retries;
  logic [2:0]  bus_adr;
  logic [15:0] bus_dat_i;
  logic        bus_ack, bus_stall = 1'b0;

  int errors = 0, checks = 0, dones = 0, we_bad = 0;
  int unsigned cyc = 0;

  always #2 clk = ~clk;

  split_timer_reader u0 (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .result(result), .retries(retries), .bus_adr(bus_adr), .bus_stb(bus_stb),
    .bus_we(bus_we), .bus_dat_i(bus_dat_i), .bus_ack(bus_ack), .bus_stall(bus_stall)
  );

  // Slave model: timer counts every clock, ack one cycle after an accepted strobe.
  logic [31:0] tmr = '0, load_val = '0;
  logic        load = 1'b0, ack_q = 1'b0, stray = 1'b0, tog = 1'b0;
  int          gcnt = 0, load_g = 0;
  logic [2:0]  adr_log[$];

  assign bus_ack = ack_q | stray;

  always @(posedge clk) begin
    ack_q <= bus_stb & ~bus_stall;
    tmr   <= load ? load_val : tmr + 1;
    if (load) begin gcnt <= load_g; tog <= 1'b0; end
    if (bus_stb && !bus_stall) begin
      adr_log.push_back(bus_adr);
      if (bus_we) we_bad++;
      if (bus_adr == 3'd4) bus_dat_i <= tmr[15:0];
      else if (bus_adr == 3'd5) begin
        if (gcnt > 0 && !load) begin
          bus_dat_i <= tmr[31:16] ^ {15'd0, tog};
          tog  <= ~tog;
          gcnt <= gcnt - 1;
        end else bus_dat_i <= tmr[31:16];
      end else bus_dat_i <= 16'hDEAD;
    end
  end

  function automatic logic [39:0] predict(input logic [31:0] t0, input int forced);
    logic [31:0] t, t4, t2;
    int r;
    t = t0 + 32'(6 * forced);
    r = (forced > 255) ? 255 : forced;
    t4 = t + 32'd4;
    while (t[31:16] != t4[31:16]) begin
      t = t + 32'd6;
      t4 = t + 32'd4;
      if (r < 255) r++;
    end
    t2 = t + 32'd2;
    return {8'(r), t[31:16], t2[15:0]};
  endfunction

  logic [39:0] expq[$];
  logic        done_d = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every done.
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (done_d) chk(!done, "R6 done width", 64'(done), 64'd0);
      if (done) begin
        dones++;
        chk(!busy, "R6 busy at done", 64'(busy), 64'd0);
        if (expq.size() == 0) chk(1'b0, "R9 unexpected done", 64'(result), 64'd0);
        else begin
          logic [39:0] e;
          e = expq.pop_front();
          chk(result == e[31:0], "R6 result", 64'(result), 64'(e[31:0]));
          chk(retries == e[39:32], "R7/R8 retries", 64'(retries), 64'(e[39:32]));
        end
      end
    end
    done_d = done & ~rst;
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    wait (cyc > 150000);
    chk(1'b0, "watchdog", 64'(cyc), 64'd0);
    finish_run();
  end

  task automatic run(input logic [31:0] v, input int d, input int forced, input bit poke);
    logic [39:0] e;
    int n0;
    e = predict(v + 32'(d), forced);
    expq.push_back(e);
    adr_log.delete();
    n0 = dones;
    @(negedge clk);
    load_val = v; load = 1'b1; load_g = 2 * forced; start = 1'b1; bus_stall = (d > 0);
    @(negedge clk);
    load = 1'b0; start = 1'b0;
    for (int i = 0; i < d; i++) begin
      chk(bus_stb && bus_adr == 3'd5, "R5 hold under stall", {bus_stb, 61'd0, bus_adr}, 64'd5);
      @(negedge clk);
    end
    bus_stall = 1'b0;
    if (poke) begin
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(dones == n0 + 1, "R9 one done per start", 64'(dones - n0), 64'd1);
    chk(adr_log.size() == 3 * (int'(e[39:32]) + 1) || forced > 255, "R4/R7 strobe count",
        64'(adr_log.size()), 64'(3 * (int'(e[39:32]) + 1)));
    if (forced == 0 && adr_log.size() >= 3)
      chk(adr_log[0] == 3'd5 && adr_log[1] == 3'd4 && adr_log[2] == 3'd5, "R3 order",
          {adr_log[0], adr_log[1], adr_log[2]}, {3'd5, 3'd4, 3'd5});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(!busy && !bus_stb && !done && result == 0 && retries == 0, "R1 reset state",
        {busy, bus_stb, done, retries, result}, 64'd0);
    run(32'h0000_1000, 0, 0, 0);
    run(32'h0001_FFFB, 0, 0, 0);
    run(32'h0001_FFFD, 0, 0, 0);     // R7 natural rollover, one retry
    if (adr_log.size() == 6)
      chk(adr_log[3] == 3'd5 && adr_log[4] == 3'd4, "R7 restart at high",
          {adr_log[3], adr_log[4]}, {3'd5, 3'd4});
    run(32'hFFFF_FFFE, 0, 0, 0);     // R7 across the 32-bit wrap
    run(32'h0042_7000, 3, 0, 0);     // R5 stall
    run(32'h0003_0010, 0, 3, 0);     // R7 forced retries
    run(32'h0004_0000, 0, 300, 0);   // R8 saturation
    run(32'h0005_0100, 0, 0, 0);     // R8 cleared by start
    run(32'h0006_0200, 0, 0, 1);     // R9 start while busy
    // R10: stray ack while idle
    begin
      logic [31:0] r0;
      int n0;
      r0 = result; n0 = dones;
      @(negedge clk); stray = 1'b1;
      @(negedge clk); stray = 1'b0;
      repeat (2) @(negedge clk);
      chk(!busy && dones == n0 && result == r0 && !bus_stb, "R10 idle ack ignored",
          {busy, 31'(dones - n0), result}, {32'd0, r0});
    end
    run(32'h0007_0300, 0, 0, 0);
    // R1: reset in the middle of a read
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(!busy && !bus_stb && result == 0 && retries == 0, "R1 reset mid-read",
        {busy, bus_stb, retries, result}, 64'd0);
    begin
      int n0;
      n0 = dones;
      repeat (8) @(negedge clk);
      chk(dones == n0 && !busy, "R1/R10 nothing after reset", 64'(dones - n0), 64'd0);
    end
    chk(we_bad == 0, "R2 write enable low", 64'(we_bad), 64'd0);
    chk(expq.size() == 0, "R6 scoreboard drained", 64'(expq.size()), 64'd0);
    finish_run();
  end
endmodule